// File: doc/BRIEF.md
# Subtraction-Based Comparison Flag Unit

This block forms the two's-complement difference of two operands of parameter width and takes from that one subtraction every integer relation between them. The difference comes with five condition flags: the carry out of the top bit, the carry into the top bit, the sign of the result, a zero indication and signed overflow. Ten relational predicates follow from those flags alone, covering equality, inequality, and the four ordering relations in both signed and unsigned form. No separate magnitude comparator is used.

The datapath is combinational. A parameter adds one output register stage that has a clock enable and an asynchronous active-low reset. A designer puts one instance wherever a branch condition, a loop bound test or a comparison result is needed. The choice of which predicate to use is left to the logic that surrounds the block.

Top module: `cmp_flag_unit`

## Requirements
- R1: `diff` equals `op_x - op_y` modulo 2^WIDTH.
- R2: `flag_cout` is 1 exactly when `op_x >= op_y` as unsigned numbers (no borrow). `flag_cin` is the carry into the top bit of the sum `op_x + ~op_y + 1`, so that `flag_ovf == flag_cin ^ flag_cout`.
- R3: `flag_neg` is the top bit of `diff`. `flag_zero` is 1 exactly when every bit of `diff` is 0, whatever the carry out is.
- R4: `flag_ovf` is 1 exactly when the true signed difference falls outside the signed WIDTH-bit range. For example, the most negative value minus 1 sets it.
- R5: `pred[2]` (signed less-than) is N XOR V, and `pred[5]` (signed greater-or-equal) is its complement.
- R6: `pred[3]` (signed less-or-equal) is (N XOR V) OR Z, and `pred[4]` (signed greater-than) is (N XNOR V) AND NOT Z.
- R7: `pred[6]` (unsigned less-than) is NOT carry-out, and `pred[9]` (unsigned greater-or-equal) is carry-out.
- R8: `pred[7]` (unsigned less-or-equal) is NOT carry-out OR Z, and `pred[8]` (unsigned greater-than) is carry-out AND NOT Z.
- R9: `pred[0]` (equal) is Z, and `pred[1]` (not equal) is NOT Z.
- R10: When REGISTERED is 1, every output takes the result for the operands present at a rising clock edge where `en` is 1, and holds its value on edges where `en` is 0. When REGISTERED is 0, the outputs follow the operands combinationally.
- R11: When REGISTERED is 1 and `rst_n` is low, every output is 0, whatever `en` and the operands are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| en | input | 1 | Clock enable of the output stage |
| op_x | input | WIDTH | Minuend |
| op_y | input | WIDTH | Subtrahend |
| diff | output | WIDTH | Difference op_x - op_y |
| flag_cout | output | 1 | Carry out of the top bit |
| flag_cin | output | 1 | Carry into the top bit |
| flag_neg | output | 1 | Sign bit of the difference |
| flag_zero | output | 1 | Difference is zero |
| flag_ovf | output | 1 | Signed overflow |
| pred | output | 10 | Predicates: 0 eq, 1 ne, 2 slt, 3 sle, 4 sgt, 5 sge, 6 ult, 7 ule, 8 ugt, 9 uge |

## Verification
At 4 bits every operand pair is applied. This covers each sign combination, every overflow case, and every equality and near-equality case, so it separates the signed rule (N XOR V) from the unsigned rule (carry-out) on every pair where the two disagree. At 16 bits the bench first applies directed extremes: the most negative value minus 1, the most positive value minus -1, zero minus zero, and equal operands. These show whether the carry into the top bit is taken at the correct position and whether Z ignores the carry. Random operand pairs follow, with a random enable. They show that the registered stage captures data only on enabled edges and holds it otherwise.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

  localparam int PRED_COUNT = 10;

  // predicate bit positions on the pred output
  localparam int P_EQ  = 0;
  localparam int P_NE  = 1;
  localparam int P_SLT = 2;
  localparam int P_SLE = 3;
  localparam int P_SGT = 4;
  localparam int P_SGE = 5;
  localparam int P_ULT = 6;
  localparam int P_ULE = 7;
  localparam int P_UGT = 8;
  localparam int P_UGE = 9;

  typedef struct packed {
    logic cout;
    logic cin;
    logic neg;
    logic zero;
    logic ovf;
  } cfu_flags_t;

  localparam int FLAG_COUNT = $bits(cfu_flags_t);

endpackage

// File: rtl/cfu_subtractor.sv
module cfu_subtractor #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] diff,
  output logic             carry_out,
  output logic             carry_msb_in
);
  localparam int LOW = WIDTH - 1;

  logic [WIDTH-1:0] y_inv;
  logic [LOW:0]     low_sum;
  logic             top_sum;

  assign y_inv = ~y;

  // low WIDTH-1 bits plus the +1 that completes the two's complement;
  // the extra bit is the carry handed to the top position
  assign low_sum = {1'b0, x[LOW-1:0]} + {1'b0, y_inv[LOW-1:0]}
                 + {{LOW{1'b0}}, 1'b1};

  assign carry_msb_in = low_sum[LOW];
  assign top_sum      = x[LOW] ^ y_inv[LOW] ^ carry_msb_in;
  assign carry_out    = (x[LOW] & y_inv[LOW])
                      | (carry_msb_in & (x[LOW] ^ y_inv[LOW]));
  assign diff         = {top_sum, low_sum[LOW-1:0]};

endmodule

// File: rtl/cfu_flag_gen.sv
module cfu_flag_gen
  import cfu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] diff,
  input  logic             carry_out,
  input  logic             carry_msb_in,
  output cfu_flags_t       flags
);
  always_comb begin
    flags.cout = carry_out;
    flags.cin  = carry_msb_in;
    flags.neg  = diff[WIDTH-1];
    flags.zero = ~|diff;
    flags.ovf  = carry_msb_in ^ carry_out;
  end
endmodule

// File: rtl/cfu_predicate.sv
module cfu_predicate
  import cfu_pkg::*;
(
  input  cfu_flags_t             flags,
  output logic [PRED_COUNT-1:0]  pred
);
  logic less_s;

  always_comb begin
    less_s       = flags.neg ^ flags.ovf;
    pred         = '0;
    pred[P_EQ]   = flags.zero;
    pred[P_NE]   = ~flags.zero;
    pred[P_SLT]  = less_s;
    pred[P_SGE]  = ~less_s;
    pred[P_SLE]  = less_s | flags.zero;
    pred[P_SGT]  = ~less_s & ~flags.zero;
    pred[P_ULT]  = ~flags.cout;
    pred[P_UGE]  = flags.cout;
    pred[P_ULE]  = ~flags.cout | flags.zero;
    pred[P_UGT]  = flags.cout & ~flags.zero;
  end
endmodule

// File: rtl/cfu_out_stage.sv
module cfu_out_stage #(
  parameter int BITS       = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [BITS-1:0] d,
  output logic [BITS-1:0] q
);
  generate
    if (REGISTERED) begin : g_reg
      logic [BITS-1:0] q_r;
      logic [BITS-1:0] q_next;

      always_comb begin
        q_next = q_r;
        if (en) q_next = d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_next;
      end

      assign q = q_r;
    end else begin : g_pass
      logic unused_ctrl;
      assign unused_ctrl = ^{clk, rst_n, en};
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
  import cfu_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [WIDTH-1:0]      op_x,
  input  logic [WIDTH-1:0]      op_y,
  output logic [WIDTH-1:0]      diff,
  output logic                  flag_cout,
  output logic                  flag_cin,
  output logic                  flag_neg,
  output logic                  flag_zero,
  output logic                  flag_ovf,
  output logic [PRED_COUNT-1:0] pred
);
  localparam int BUS_BITS = WIDTH + FLAG_COUNT + PRED_COUNT;

  logic [WIDTH-1:0]      raw_diff;
  logic                  raw_cout;
  logic                  raw_cin;
  cfu_flags_t            raw_flags;
  cfu_flags_t            out_flags;
  logic [PRED_COUNT-1:0] raw_pred;
  logic [BUS_BITS-1:0]   bus_d;
  logic [BUS_BITS-1:0]   bus_q;

  cfu_subtractor #(.WIDTH(WIDTH)) u_sub (
    .x            (op_x),
    .y            (op_y),
    .diff         (raw_diff),
    .carry_out    (raw_cout),
    .carry_msb_in (raw_cin)
  );

  cfu_flag_gen #(.WIDTH(WIDTH)) u_flags (
    .diff         (raw_diff),
    .carry_out    (raw_cout),
    .carry_msb_in (raw_cin),
    .flags        (raw_flags)
  );

  cfu_predicate u_pred (
    .flags (raw_flags),
    .pred  (raw_pred)
  );

  assign bus_d = {raw_diff, raw_flags, raw_pred};

  cfu_out_stage #(.BITS(BUS_BITS), .REGISTERED(REGISTERED)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .d     (bus_d),
    .q     (bus_q)
  );

  assign {diff, out_flags, pred} = bus_q;
  assign flag_cout = out_flags.cout;
  assign flag_cin  = out_flags.cin;
  assign flag_neg  = out_flags.neg;
  assign flag_zero = out_flags.zero;
  assign flag_ovf  = out_flags.ovf;

endmodule

// File: rtl/cmp_flag_unit_chk.sv
module cmp_flag_unit_chk
  import cfu_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter bit REGISTERED = 1'b1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  en,
  input logic [WIDTH-1:0]      op_x,
  input logic [WIDTH-1:0]      op_y,
  input logic [WIDTH-1:0]      diff,
  input logic                  flag_cout,
  input logic                  flag_cin,
  input logic                  flag_neg,
  input logic                  flag_zero,
  input logic                  flag_ovf,
  input logic [PRED_COUNT-1:0] pred
);
  logic [WIDTH-1:0] ex;
  logic [WIDTH-1:0] ey;
  logic             live;
  logic             sgn_ovf;

  generate
    if (REGISTERED) begin : g_cap
      logic [WIDTH-1:0] cx;
      logic [WIDTH-1:0] cy;
      logic             cv;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cx <= '0;
          cy <= '0;
          cv <= 1'b0;
        end else if (en) begin
          cx <= op_x;
          cy <= op_y;
          cv <= 1'b1;
        end
      end
      assign ex   = cx;
      assign ey   = cy;
      assign live = cv;

      // R10: a disabled edge leaves the outputs unchanged
      a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(diff) && $stable(pred) && $stable(flag_ovf)));
    end else begin : g_comb
      assign ex   = op_x;
      assign ey   = op_y;
      assign live = 1'b1;
    end
  endgenerate

  assign sgn_ovf = (ex[WIDTH-1] != ey[WIDTH-1]) && (diff[WIDTH-1] != ex[WIDTH-1]);

  a_r1_diff: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> diff == WIDTH'(ex - ey));
  a_r2_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> flag_cout == (ex >= ey));
  a_r3_zero: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> flag_zero == (diff == '0));
  a_r4_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> flag_ovf == sgn_ovf);
  a_r5_slt: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> pred[P_SLT] == ($signed(ex) < $signed(ey)));
  a_r6_sgt: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> pred[P_SGT] == ($signed(ex) > $signed(ey)));
  a_r7_ult: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> pred[P_ULT] == (ex < ey));
  a_r8_ule: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> pred[P_ULE] == (ex <= ey));
  a_r9_eq: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> pred[P_EQ] == (ex == ey));

endmodule

bind cmp_flag_unit cmp_flag_unit_chk #(
  .WIDTH      (WIDTH),
  .REGISTERED (REGISTERED)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .op_x      (op_x),
  .op_y      (op_y),
  .diff      (diff),
  .flag_cout (flag_cout),
  .flag_cin  (flag_cin),
  .flag_neg  (flag_neg),
  .flag_zero (flag_zero),
  .flag_ovf  (flag_ovf),
  .pred      (pred)
);

// File: tb/sim_cmp_flag_unit.sv
module sim_cmp_flag_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WA = 16;
  localparam int WB = 4;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic clk = 1'b0;
  logic rst_n;
  logic en;
  logic [WA-1:0] xa, ya, da;
  logic [WB-1:0] xb, yb, db;
  logic [9:0] pa, pb;
  logic coa, cia, na, za, va;
  logic cob, cib, nb, zb, vb;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_flag_unit #(.WIDTH(WA), .REGISTERED(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .op_x(xa), .op_y(ya), .diff(da),
    .flag_cout(coa), .flag_cin(cia), .flag_neg(na), .flag_zero(za),
    .flag_ovf(va), .pred(pa));

  cmp_flag_unit #(.WIDTH(WB), .REGISTERED(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .en(1'b1), .op_x(xb), .op_y(yb), .diff(db),
    .flag_cout(cob), .flag_cin(cib), .flag_neg(nb), .flag_zero(zb),
    .flag_ovf(vb), .pred(pb));

  task automatic chk(string ph, string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", ph, tag, act, exp);
    end
  endtask

  // behavioural reference from plain integer arithmetic
  task automatic ref_model(input int w, input longint ux, input longint uy,
                           output longint d, output bit [4:0] f, output bit [9:0] p);
    longint m, sx, sy, sd;
    bit co, v, n, z;
    m  = longint'(1) << w;
    d  = (ux - uy + m) % m;
    sx = (ux >= m/2) ? ux - m : ux;
    sy = (uy >= m/2) ? uy - m : uy;
    sd = sx - sy;
    co = (ux >= uy);
    v  = (sd > m/2 - 1) || (sd < -(m/2));
    n  = ((d >> (w-1)) & 1) != 0;
    z  = (d == 0);
    f  = {co, v ^ co, n, z, v};
    p[0] = (sx == sy); p[1] = (sx != sy);
    p[2] = (sx <  sy); p[3] = (sx <= sy);
    p[4] = (sx >  sy); p[5] = (sx >= sy);
    p[6] = (ux <  uy); p[7] = (ux <= uy);
    p[8] = (ux >  uy); p[9] = (ux >= uy);
  endtask

  task automatic cmp_all(string ph, longint ad, bit [4:0] af, bit [9:0] ap,
                         longint ed, bit [4:0] ef, bit [9:0] ep);
    chk(ph, "R1 diff", ad, ed);
    chk(ph, "R2 cout", longint'(af[4]), longint'(ef[4]));
    chk(ph, "R2 cin",  longint'(af[3]), longint'(ef[3]));
    chk(ph, "R3 neg",  longint'(af[2]), longint'(ef[2]));
    chk(ph, "R3 zero", longint'(af[1]), longint'(ef[1]));
    chk(ph, "R4 ovf",  longint'(af[0]), longint'(ef[0]));
    chk(ph, "R5 slt/sge", longint'({ap[2], ap[5]}), longint'({ep[2], ep[5]}));
    chk(ph, "R6 sle/sgt", longint'({ap[3], ap[4]}), longint'({ep[3], ep[4]}));
    chk(ph, "R7 ult/uge", longint'({ap[6], ap[9]}), longint'({ep[6], ep[9]}));
    chk(ph, "R8 ule/ugt", longint'({ap[7], ap[8]}), longint'({ep[7], ep[8]}));
    chk(ph, "R9 eq/ne",   longint'({ap[0], ap[1]}), longint'({ep[0], ep[1]}));
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    longint ed = 0, rd;
    bit [4:0] ef = '0, rf;
    bit [9:0] ep = '0, rp;
    logic [WA-1:0] dx [8] = '{16'h8000, 16'h7fff, 16'h0000, 16'h1234,
                              16'h0000, 16'hffff, 16'h8000, 16'h7fff};
    logic [WA-1:0] dy [8] = '{16'h0001, 16'hffff, 16'h0000, 16'h1234,
                              16'h0001, 16'h0000, 16'h7fff, 16'h8000};
    rst_n = 1'b0; en = 1'b1; xa = 16'h8000; ya = 16'h0001;
    xb = '0; yb = '0;
    repeat (3) @(negedge clk);
    // R11: reset holds all outputs at zero even with en=1
    cmp_all("R11 reset", longint'(da), {coa, cia, na, za, va}, pa, 0, '0, '0);
    en = 1'b0;
    rst_n = 1'b1;

    // R10: registered path, directed extremes then random with random enable
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      cmp_all("R10 reg", longint'(da), {coa, cia, na, za, va}, pa, ed, ef, ep);
      if (i < 8) begin
        xa = dx[i]; ya = dy[i]; en = 1'b1;
      end else begin
        xa = WA'($urandom); ya = WA'($urandom);
        if (i % 7 == 0) ya = xa;
        en = ($urandom % 4) != 0;
      end
      if (en) begin
        ref_model(WA, longint'(xa), longint'(ya), rd, rf, rp);
        ed = rd; ef = rf; ep = rp;
      end
    end

    // R10 combinational variant: exhaustive at small width
    for (int a = 0; a < (1 << WB); a++) begin
      for (int b = 0; b < (1 << WB); b++) begin
        @(negedge clk);
        xb = WB'(a); yb = WB'(b);
        #1;
        ref_model(WB, longint'(a), longint'(b), rd, rf, rp);
        cmp_all("comb", longint'(db), {cob, cib, nb, zb, vb}, pb, rd, rf, rp);
      end
    end
    done = 1;
    finish_run();
  end
endmodule